// File: doc/BRIEF.md
# Broadcast-Input Systolic Convolution Array

This block computes a k-tap convolution over a stream of signed samples. Each tap is a cell with its own fixed coefficient. Every accepted sample goes to all cells in the same cycle. A partial sum moves one cell further toward the output end each time a sample is accepted. The cell at the far end holds the finished result, and that cell's register is also the output register. For a frame of samples x_1..x_N, the block emits N+1-k results: y_i = w_1·x_i + w_2·x_{i+1} + ... + w_k·x_{i+k-1}.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. The array advances only when a sample is accepted. A sample is accepted when s_valid and s_ready are both high at a clock edge. Back-pressure works as follows: s_ready is high exactly when the output register is empty or is being drained in the same cycle. A result that has not been taken therefore blocks new samples. Nothing is ever dropped. Coefficients are written through a plain write port, one tap per cycle. A frame ends with the sample that carries s_last. The following sample starts a new frame, and the warm-up begins again.

Top module: `bcast_conv_array`

## Requirements
- R1: The tap written at index j (0-based) holds w_{j+1}. It multiplies the sample accepted k-1-j samples before the newest one. Each result therefore equals sum over j of w_{j+1}·x_{i+j}, where x_{i+k-1} is the sample whose acceptance produced it.
- R2: In each frame, the first k-1 accepted samples produce no result. Every later accepted sample produces exactly one result, so a frame of N ≥ k samples yields N+1-k results.
- R3: Results are signed and AW = XW+WW+ceil(log2 k) bits wide. They are exact for every combination of extreme sample and coefficient values, for example all samples and all coefficients equal to -2^(XW-1).
- R4: s_ready equals (not m_valid) or m_ready. While m_valid is high and m_ready is low, m_data and m_last keep their values.
- R5: The sample accepted with s_last=1 is the last one of its frame. The result it produces carries m_last=1, and all other results carry m_last=0. A frame shorter than k produces nothing. The next frame's results use only that frame's samples.
- R6: When w_we=1 at a clock edge, w_data (signed) is stored into tap w_idx. Samples accepted at later edges use the new value. Reloading coefficients between frames changes the next frame's results.
- R7: After reset, m_valid is 0, s_ready is 1, and all coefficients are 0. A frame sent before any coefficient write therefore yields results of 0.
- R8: Cycles with s_valid=0 leave the array unchanged. A frame sent with idle gaps gives the same results as the same frame sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Array can take a sample this cycle |
| s_data | input | XW | Signed sample, broadcast to all taps |
| s_last | input | 1 | Marks the final sample of a frame |
| w_we | input | 1 | Coefficient write strobe |
| w_idx | input | ceil(log2 TAPS) | Tap index to write |
| w_data | input | WW | Signed coefficient value |
| m_valid | output | 1 | Result present |
| m_ready | input | 1 | Consumer takes the result |
| m_data | output | XW+WW+ceil(log2 TAPS) | Signed convolution result |
| m_last | output | 1 | Result produced by the frame's last sample |

## Verification
The hardest case to reach is a stalled result that sits while a new frame is arriving. In that state the output register must stay frozen, and no partial sum may move. Then, once the consumer accepts, the warm-up count must resume with the samples that were held back. Random gaps on s_valid combined with random drops of m_ready, across frames of random length (including frames shorter than k and frames of exactly k), put stalls at every point in the warm-up. Directed frames of extreme values drive the result to its widest value.

// File: rtl/conv_pkg.sv
package conv_pkg;
  function automatic int acc_width(input int xw, input int ww, input int taps);
    return xw + ww + $clog2(taps);
  endfunction
endpackage

// File: rtl/conv_cell.sv
module conv_cell #(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic signed [XW-1:0] x_bc,
  input  logic signed [AW-1:0] psum_in,
  input  logic                 w_we,
  input  logic signed [WW-1:0] w_din,
  output logic signed [AW-1:0] psum_out
);
  localparam int PW = XW + WW;

  logic signed [WW-1:0] coef_q;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] sum_nx;

  always_comb begin
    prod   = x_bc * coef_q;
    sum_nx = psum_in + AW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q   <= '0;
      psum_out <= '0;
    end else begin
      if (adv)  psum_out <= sum_nx;
      if (w_we) coef_q   <= w_din;
    end
  end
endmodule

// File: rtl/conv_frame_ctrl.sv
module conv_frame_ctrl #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic last_in,
  input  logic m_ready,
  output logic m_valid,
  output logic m_last
);
  localparam int CW = (TAPS > 2) ? $clog2(TAPS) : 1;
  localparam logic [CW-1:0] FULL = CW'(TAPS - 1);

  logic [CW-1:0] fill_q;
  logic          warm;

  assign warm = (fill_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      m_valid <= 1'b0;
      m_last  <= 1'b0;
    end else if (fire) begin
      if (last_in)    fill_q <= '0;
      else if (!warm) fill_q <= fill_q + 1'b1;
      m_valid <= warm;
      m_last  <= warm & last_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/bcast_conv_array.sv
module bcast_conv_array #(
  parameter int TAPS = 4,
  parameter int XW   = 8,
  parameter int WW   = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   s_valid,
  output logic                                   s_ready,
  input  logic [XW-1:0]                          s_data,
  input  logic                                   s_last,
  input  logic                                   w_we,
  input  logic [$clog2(TAPS)-1:0]                w_idx,
  input  logic [WW-1:0]                          w_data,
  output logic                                   m_valid,
  input  logic                                   m_ready,
  output logic [XW+WW+$clog2(TAPS)-1:0]          m_data,
  output logic                                   m_last
);
  import conv_pkg::*;
  localparam int AW = acc_width(XW, WW, TAPS);
  localparam int IW = $clog2(TAPS);

  logic                 fire;
  logic signed [AW-1:0] link [TAPS+1];

  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;
  assign link[0] = '0;

  for (genvar c = 0; c < TAPS; c++) begin : g_tap
    logic sel;
    assign sel = w_we && (w_idx == IW'(c));
    conv_cell #(.XW(XW), .WW(WW), .AW(AW)) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (fire),
      .x_bc     ($signed(s_data)),
      .psum_in  (link[c]),
      .w_we     (sel),
      .w_din    ($signed(w_data)),
      .psum_out (link[c+1])
    );
  end

  assign m_data = link[TAPS];

  conv_frame_ctrl #(.TAPS(TAPS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .last_in (s_last),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_last  (m_last)
  );
endmodule

// File: rtl/conv_array_checker.sv
module conv_array_checker #(
  parameter int TAPS = 4,
  parameter int AW   = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          s_last,
  input logic          m_valid,
  input logic          m_ready,
  input logic [AW-1:0] m_data,
  input logic          m_last
);
  logic [7:0] seen_q;
  logic       acc;
  assign acc = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (acc) begin
      if (s_last) seen_q <= '0;
      else if (seen_q < 8'(TAPS - 1)) seen_q <= seen_q + 8'd1;
    end
  end

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_no_accept_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  p_warmup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen_q < 8'(TAPS - 1)) |=> !m_valid);

  p_steady_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen_q >= 8'(TAPS - 1)) |=> m_valid);

  p_last_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);
endmodule

bind bcast_conv_array conv_array_checker #(.TAPS(TAPS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last)
);

// File: tb/bcast_conv_array_tb_top.sv
module bcast_conv_array_tb_top;
  localparam int K  = 4;
  localparam int XW = 8;
  localparam int WW = 8;
  localparam int AW = XW + WW + $clog2(K);

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, s_last = 0;
  logic [XW-1:0] s_data = '0;
  logic w_we = 0;
  logic [$clog2(K)-1:0] w_idx = '0;
  logic [WW-1:0] w_data = '0;
  logic m_valid, m_ready = 1, m_last;
  logic [AW-1:0] m_data;

  always #5 clk = ~clk;

  bcast_conv_array #(.TAPS(K), .XW(XW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .w_we(w_we), .w_idx(w_idx),
    .w_data(w_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  longint wt[K];
  longint fr[$];
  longint exp_q[$];
  bit     expl_q[$];
  bit bp_on = 0, gaps_on = 0;
  bit nx_valid = 0, nx_last = 0, nx_we = 0;
  longint nx_x = 0, nx_w = 0;
  int nx_idx = 0;
  bit prev_stall = 0, prev_last = 0;
  logic [AW-1:0] prev_data = '0;
  bit fired;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_accept(longint x, bit last);
    longint y;
    fr.push_back(x);
    if (fr.size() >= K) begin
      y = 0;
      for (int j = 0; j < K; j++) y += wt[j] * fr[fr.size() - K + j];
      exp_q.push_back(y);
      expl_q.push_back(last);
    end
    if (last) fr.delete();
  endfunction

  task automatic step();
    @(negedge clk);
    s_valid = nx_valid;
    s_data  = XW'(nx_x);
    s_last  = nx_last;
    w_we    = nx_we;
    w_idx   = nx_idx[$clog2(K)-1:0];
    w_data  = WW'(nx_w);
    m_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (prev_stall) begin
      check(m_valid && m_data == prev_data && m_last == prev_last, "R4", "stall hold",
            $signed(m_data), $signed(prev_data));
    end
    if (m_valid && !m_ready) check(!s_ready, "R4", "s_ready during stall", s_ready, 0);
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected result", $signed(m_data), 0);
      end else begin
        longint e;
        bit el;
        e = exp_q.pop_front();
        el = expl_q.pop_front();
        check(longint'($signed(m_data)) == e, cur_req, "result", $signed(m_data), e);
        check(m_last == el, "R5", "m_last", m_last, el);
      end
    end
    fired = s_valid && s_ready;
    if (fired) model_accept($signed(s_data), s_last);
    if (w_we) wt[nx_idx] = $signed(w_data);
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
    prev_last  = m_last;
  endtask

  task automatic send(longint x, bit last);
    nx_we = 0;
    forever begin
      if (gaps_on && ($urandom % 4 == 0)) begin
        nx_valid = 0;
        step();
      end else begin
        nx_valid = 1; nx_x = x; nx_last = last;
        step();
        if (fired) break;
      end
    end
    nx_valid = 0; nx_last = 0;
  endtask

  task automatic load_w(int idx, longint v);
    nx_valid = 0; nx_we = 1; nx_idx = idx; nx_w = v;
    step();
    nx_we = 0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) step();
    step(); step();
    check(exp_q.size() == 0, req, "pending results after drain", exp_q.size(), 0);
  endtask

  task automatic frame_ramp(int n, longint start);
    for (int i = 0; i < n; i++) send(start + i, i == n - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < K; j++) wt[j] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(m_valid == 0, "R7", "m_valid after reset", m_valid, 0);
    check(s_ready == 1, "R7", "s_ready after reset", s_ready, 1);

    cur_req = "R7";
    frame_ramp(6, 3);
    drain("R2");

    cur_req = "R1";
    for (int j = 0; j < K; j++) load_w(j, j + 1);
    frame_ramp(8, 1);
    drain("R2");
    frame_ramp(5, -20);
    drain("R2");

    cur_req = "R3";
    for (int j = 0; j < K; j++) load_w(j, -128);
    for (int i = 0; i < 6; i++) send(-128, i == 5);
    drain("R3");
    for (int j = 0; j < K; j++) load_w(j, 127);
    for (int i = 0; i < 5; i++) send(-128, i == 4);
    drain("R3");

    cur_req = "R5";
    load_w(0, 5); load_w(1, -3); load_w(2, 7); load_w(3, 2);
    frame_ramp(K - 1, 10);
    frame_ramp(K, 40);
    frame_ramp(1, 9);
    frame_ramp(K + 1, -7);
    drain("R5");

    cur_req = "R6";
    load_w(2, -50);
    frame_ramp(6, 2);
    drain("R6");

    cur_req = "R8";
    gaps_on = 1;
    frame_ramp(7, 11);
    drain("R8");

    cur_req = "R4";
    bp_on = 1;
    for (int f = 0; f < 40; f++) begin
      int n;
      if (f % 5 == 0)
        for (int j = 0; j < K; j++) load_w(j, $signed(8'($urandom)));
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) send($signed(8'($urandom)), i == n - 1);
    end
    drain("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule